// File: doc/BRIEF.md
# Five-Function Integer ALU with Status Flags

A purely combinational arithmetic logic unit working on two `W`-bit operands (32 by default). A 3-bit operation code selects bitwise AND, bitwise OR, addition, subtraction or a signed less-than comparison. Alongside the result the unit reports a zero flag, a signed overflow flag and the adder's carry-out. The block has no clock or reset; it is meant to sit in the execute stage of a simple integer datapath, with operands and operation code arriving from decode and the flags feeding branch and exception logic.

One adder serves addition, subtraction and comparison. For subtraction the second operand is inverted bit by bit and the carry-in is forced to one. The top bit of the operation code acts as that invert/carry-in control, so the subtract and compare codes share one adder setup. Overflow is taken from the carries on either side of the most significant bit. The comparison places the raw sign bit of the difference in bit 0, and this bit is not corrected when the difference overflows.

Top module: `alu_core`

## Requirements
- R1: Code 3'b000 drives `result_o` with `a_i & b_i`.
- R2: Code 3'b001 drives `result_o` with `a_i | b_i`.
- R3: Code 3'b010 drives `result_o` with the low `W` bits of `a_i + b_i`, and `carry_o` with bit `W` of that sum.
- R4: Code 3'b110 drives `result_o` with the low `W` bits of `a_i + ~b_i + 1`, and `carry_o` with bit `W` of that sum. The carry is therefore 1 exactly when `a_i >= b_i` as unsigned values.
- R5: Code 3'b111 computes `a_i + ~b_i + 1`, places bit `W-1` of that difference in `result_o[0]` and clears `result_o[W-1:1]`. `carry_o` and `overflow_o` are those of the subtraction.
- R6: For codes 010, 110 and 111, `overflow_o` is the carry into bit `W-1` XORed with the carry out of bit `W-1`. It is therefore 1 exactly when the signed add or subtract result does not fit in `W` bits.
- R7: For every code, `zero_o` is 1 if and only if all bits of `result_o` are 0.
- R8: For codes 000 and 001, `carry_o` and `overflow_o` are 0.
- R9: Codes 011, 100 and 101 give `result_o` = 0 with `carry_o` = 0 and `overflow_o` = 0, so `zero_o` = 1.
- R10: When a code 3'b111 difference overflows, `result_o[0]` still follows the raw sign bit. For example, A = 0x7FFFFFFF and B = 0x80000000 give a result of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation code |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| result_o | output | W | Operation result |
| zero_o | output | 1 | High when every result bit is 0 |
| overflow_o | output | 1 | Signed overflow of add, subtract or compare |
| carry_o | output | 1 | Carry out of the adder's top bit |

## Verification
The hardest case to reach is a compare whose subtraction overflows. Only operands of opposite sign near the ends of the range produce it, and uniform random operands rarely land there. The stimulus therefore picks operands from a pool that includes the most positive and most negative values, zero and ±1, and adds directed vectors for the overflow compare. Zero results from add and subtract are just as rare at random, so the bench also feeds vectors where B equals A or is A's negation.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam logic [2:0] OP_AND = 3'b000;
  localparam logic [2:0] OP_OR  = 3'b001;
  localparam logic [2:0] OP_ADD = 3'b010;
  localparam logic [2:0] OP_SUB = 3'b110;
  localparam logic [2:0] OP_SLT = 3'b111;

  typedef enum logic [1:0] {
    SEL_LOGIC = 2'd0,
    SEL_SUM   = 2'd1,
    SEL_SIGN  = 2'd2,
    SEL_NONE  = 2'd3
  } res_sel_e;

  function automatic res_sel_e decode_sel(input logic [2:0] op);
    case (op)
      OP_AND, OP_OR:  return SEL_LOGIC;
      OP_ADD, OP_SUB: return SEL_SUM;
      OP_SLT:         return SEL_SIGN;
      default:        return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sel_or_i,
  output logic [W-1:0] y_o
);
  always_comb y_o = sel_or_i ? (a_i | b_i) : (a_i & b_i);
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         cin_msb_o
);
  localparam int LW = W - 1;

  logic [W-1:0] b_eff;
  logic [LW:0]  low_sum;   // carry into msb lands in the top bit
  logic [1:0]   msb_sum;

  always_comb begin
    b_eff     = sub_i ? ~b_i : b_i;
    low_sum   = {1'b0, a_i[LW-1:0]} + {1'b0, b_eff[LW-1:0]} + {{LW{1'b0}}, sub_i};
    cin_msb_o = low_sum[LW];
    msb_sum   = {1'b0, a_i[W-1]} + {1'b0, b_eff[W-1]} + {1'b0, cin_msb_o};
    sum_o     = {msb_sum[0], low_sum[LW-1:0]};
    cout_o    = msb_sum[1];
  end
endmodule

// File: rtl/alu_result_mux.sv
module alu_result_mux
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [2:0]   op_i,
  input  logic [W-1:0] logic_y_i,
  input  logic [W-1:0] sum_i,
  input  logic         cout_i,
  input  logic         cin_msb_i,
  output logic [W-1:0] result_o,
  output logic         zero_o,
  output logic         overflow_o,
  output logic         carry_o
);
  res_sel_e sel;
  logic     ovf_raw;

  always_comb begin
    sel     = decode_sel(op_i);
    ovf_raw = cin_msb_i ^ cout_i;
    result_o   = '0;
    overflow_o = 1'b0;
    carry_o    = 1'b0;
    case (sel)
      SEL_LOGIC: result_o = logic_y_i;
      SEL_SUM: begin
        result_o   = sum_i;
        overflow_o = ovf_raw;
        carry_o    = cout_i;
      end
      SEL_SIGN: begin
        result_o[0] = sum_i[W-1];  // raw sign, no overflow correction
        overflow_o  = ovf_raw;
        carry_o     = cout_i;
      end
      default: ;
    endcase
    zero_o = ~|result_o;
  end
endmodule

// File: rtl/alu_core.sv
module alu_core #(
  parameter int W = 32
) (
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] result_o,
  output logic         zero_o,
  output logic         overflow_o,
  output logic         carry_o
);
  logic [W-1:0] logic_y;
  logic [W-1:0] sum;
  logic         cout;
  logic         cin_msb;

  alu_logic_unit #(.W(W)) u_logic (
    .a_i      (a_i),
    .b_i      (b_i),
    .sel_or_i (op_i[0]),
    .y_o      (logic_y)
  );

  // op_i[2] is both the B-invert and the carry-in control
  alu_addsub #(.W(W)) u_addsub (
    .a_i       (a_i),
    .b_i       (b_i),
    .sub_i     (op_i[2]),
    .sum_o     (sum),
    .cout_o    (cout),
    .cin_msb_o (cin_msb)
  );

  alu_result_mux #(.W(W)) u_mux (
    .op_i       (op_i),
    .logic_y_i  (logic_y),
    .sum_i      (sum),
    .cout_i     (cout),
    .cin_msb_i  (cin_msb),
    .result_o   (result_o),
    .zero_o     (zero_o),
    .overflow_o (overflow_o),
    .carry_o    (carry_o)
  );
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int W = 32
) (
  input logic [2:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] result_o,
  input logic         zero_o,
  input logic         overflow_o,
  input logic         carry_o
);
  logic [W:0] wide_add;
  logic [W:0] wide_sub;

  always_comb begin
    wide_add = {1'b0, a_i} + {1'b0, b_i};
    wide_sub = {1'b0, a_i} + {1'b0, ~b_i} + {{W{1'b0}}, 1'b1};
    if (op_i == 3'b010) begin
      AST_ADD_SUM: assert ({carry_o, result_o} == wide_add) else $error("add mismatch"); // R3
      AST_ADD_OVF: assert (overflow_o == ((a_i[W-1] == b_i[W-1]) && (result_o[W-1] != a_i[W-1])))
        else $error("add overflow mismatch"); // R6
    end
    if (op_i == 3'b110) begin
      AST_SUB_DIFF: assert ({carry_o, result_o} == wide_sub) else $error("sub mismatch"); // R4
    end
    if (op_i == 3'b111) begin
      AST_SLT_UPPER_CLEAR: assert (result_o[W-1:1] == '0) else $error("slt upper bits set"); // R5
      AST_SLT_RAW_SIGN: assert (result_o[0] == wide_sub[W-1]) else $error("slt sign mismatch"); // R10
    end
    if (op_i == 3'b000 || op_i == 3'b001) begin
      AST_LOGIC_NO_FLAGS: assert (!carry_o && !overflow_o) else $error("logic flags set"); // R8
    end
    if (op_i == 3'b011 || op_i == 3'b100 || op_i == 3'b101) begin
      AST_UNUSED_QUIET: assert (result_o == '0 && !carry_o && !overflow_o && zero_o)
        else $error("unused code active"); // R9
    end
    if (zero_o) begin
      AST_ZERO_MEANS_EMPTY: assert (result_o == '0) else $error("zero with bits set"); // R7
    end
  end
endmodule

bind alu_core alu_core_chk #(.W(W)) u_chk (
  .op_i       (op_i),
  .a_i        (a_i),
  .b_i        (b_i),
  .result_o   (result_o),
  .zero_o     (zero_o),
  .overflow_o (overflow_o),
  .carry_o    (carry_o)
);

// File: tb/tb_alu_core.sv
module tb_alu_core;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic [2:0]   op;
  logic [W-1:0] a, b;
  logic [W-1:0] result;
  logic         zero, ovf, carry;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  alu_core #(.W(W)) dut (
    .op_i(op), .a_i(a), .b_i(b),
    .result_o(result), .zero_o(zero), .overflow_o(ovf), .carry_o(carry)
  );

  function automatic logic [W:0] exp_wide(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] s;
    case (o)
      3'b010:  s = {1'b0, x} + {1'b0, y};
      3'b110, 3'b111: s = {1'b0, x} + {1'b0, ~y} + 1;
      default: s = '0;
    endcase
    return s;
  endfunction

  function automatic logic [W-1:0] exp_result(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] s;
    s = exp_wide(o, x, y);
    case (o)
      3'b000: return x & y;
      3'b001: return x | y;
      3'b010, 3'b110: return s[W-1:0];
      3'b111: return {{(W-1){1'b0}}, s[W-1]};
      default: return '0;
    endcase
  endfunction

  function automatic logic exp_carry(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] s;
    s = exp_wide(o, x, y);
    return (o == 3'b010 || o == 3'b110 || o == 3'b111) ? s[W] : 1'b0;
  endfunction

  // signed-range rule, independent of the carry-XOR formulation
  function automatic logic exp_ovf(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] s;
    s = exp_wide(o, x, y);
    if (o == 3'b010) return (x[W-1] == y[W-1]) && (s[W-1] != x[W-1]);
    if (o == 3'b110 || o == 3'b111) return (x[W-1] != y[W-1]) && (s[W-1] != x[W-1]);
    return 1'b0;
  endfunction

  function automatic string op_tag(input logic [2:0] o);
    case (o)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b110: return "R4";
      3'b111: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", tag, op, a, b, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] er;
    op = o; a = x; b = y;
    @(negedge clk);
    er = exp_result(o, x, y);
    check(op_tag(o), result, er);
    check((o == 3'b000 || o == 3'b001) ? "R8" : (o[0] ^ o[1]) && o != 3'b001 && o != 3'b010 ? "R9" : "R6",
          {{(W-1){1'b0}}, ovf}, {{(W-1){1'b0}}, exp_ovf(o, x, y)});
    check((o == 3'b000 || o == 3'b001) ? "R8" : op_tag(o),
          {{(W-1){1'b0}}, carry}, {{(W-1){1'b0}}, exp_carry(o, x, y)});
    check("R7", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, (er == '0)});
  endtask

  function automatic logic [W-1:0] pick_operand();
    case ($urandom % 8)
      0: return 32'h7FFF_FFFF;
      1: return 32'h8000_0000;
      2: return 32'h0000_0000;
      3: return 32'hFFFF_FFFF;
      4: return 32'h0000_0001;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    op = 3'b000; a = '0; b = '0;
    void'($urandom(32'd20240611));
    @(negedge clk);
    // idle state with zero operands
    check("R7", {{(W-1){1'b0}}, zero}, {{(W-1){1'b0}}, 1'b1});

    // directed corner cases
    apply(3'b000, 32'hF0F0_F0F0, 32'hFF00_FF00);              // R1
    apply(3'b001, 32'hF0F0_F0F0, 32'h0F0F_0F0F);              // R2
    apply(3'b010, 32'hFFFF_FFFF, 32'h0000_0001);              // R3 carry, zero
    apply(3'b010, 32'h7FFF_FFFF, 32'h0000_0001);              // R6 positive overflow
    apply(3'b010, 32'h8000_0000, 32'h8000_0000);              // R6 negative overflow
    apply(3'b110, 32'h0000_0005, 32'h0000_0005);              // R4 equal -> zero, carry 1
    apply(3'b110, 32'h0000_0003, 32'h0000_0005);              // R4 borrow -> carry 0
    apply(3'b110, 32'h8000_0000, 32'h0000_0001);              // R6 sub overflow
    apply(3'b111, 32'h0000_0003, 32'h0000_0005);              // R5 less
    apply(3'b111, 32'h0000_0005, 32'h0000_0003);              // R5 not less
    apply(3'b111, 32'hFFFF_FFFF, 32'h0000_0000);              // R5 negative vs zero
    apply(3'b111, 32'h7FFF_FFFF, 32'h8000_0000);              // R10 raw sign -> 1
    apply(3'b111, 32'h8000_0000, 32'h0000_0001);              // R10 raw sign -> 0
    apply(3'b011, 32'hFFFF_FFFF, 32'hFFFF_FFFF);              // R9
    apply(3'b100, 32'h1234_5678, 32'h8765_4321);              // R9
    apply(3'b101, 32'h8000_0000, 32'h8000_0000);              // R9
    apply(3'b000, 32'hAAAA_AAAA, 32'h5555_5555);              // R7 logic zero

    // constrained random over every code
    for (int i = 0; i < 4000; i++) begin
      logic [2:0]   o;
      logic [W-1:0] x, y;
      o = 3'($urandom % 8);
      x = pick_operand();
      case ($urandom % 6)
        0: y = x;
        1: y = -x;
        default: y = pick_operand();
      endcase
      apply(o, x, y);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule